// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This unit decides where a 32-bit RISC core with fixed 32-bit instructions fetches next. It owns the program counter register. Each cycle it takes the instruction word at the current PC and the two source operand values that the register file has read for it. It then settles the next PC: sequential flow, conditional branches, PC-relative jumps, jump-and-link, register-indirect jumps and halting. All of this is combinational from the instruction and operands. The only state is the PC, a sticky halt flag and a free-running cycle counter that stops once the core halts.

For jump-and-link the unit also produces the return-address write: an enable, the value and the destination register index. The register file applies that write. A link aimed at register zero is dropped at the source. Opcodes beyond the defined range behave as no-ops and raise a flag for the surrounding core.

Top module: `pc_sequencer`

## Requirements
- R1: While reset (`rst_n` low) is applied, and right after it, `pc` is 0, `halted` is 0 and `cycle_count` is 0.
- R2: Opcodes (instruction bits [31:26]) 0x00 to 0x11, 0x19 and 0x1B give `next_pc = pc + 4`, with `link_we` and `illegal` low.
- R3: Opcode 0x12 (branch if `src_a == src_b`) and 0x13 (branch if not equal) go to `pc + sext(instr[17:0]) * 4` when the condition holds, and to `pc + 4` when it does not.
- R4: Opcode 0x14 (branch if `src_a < src_b`) and 0x15 (branch if `src_a >= src_b`) compare the operands as signed two's complement values and use the same targets as R3.
- R5: Opcode 0x16 gives `next_pc = pc + sext(instr[21:0]) * 4` with `link_we` low.
- R6: Opcode 0x17 jumps like R5. It drives `link_data = pc + 4` and `link_dst = instr[25:22]`, and raises `link_we` only when `link_dst` is not 0.
- R7: Opcode 0x18 gives `next_pc = src_a`.
- R8: Opcode 0x1A gives `next_pc = pc`. From the following clock edge `halted` is 1, and it stays 1 until reset.
- R9: `cycle_count` rises by one on every clock edge at which `halted` is 0, and holds its value while `halted` is 1.
- R10: Opcodes 0x1C to 0x3F raise `illegal` and give `next_pc = pc + 4` with `link_we` low.
- R11: While `halted` is 0, each clock edge loads `pc` with the `next_pc` of the cycle before.
- R12: While `halted` is 1, whatever the instruction: `next_pc = pc`, `link_we = 0`, `illegal = 0`, and `pc` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 32 | Instruction word fetched at `pc` |
| src_a | input | 32 | First source operand value |
| src_b | input | 32 | Second source operand value |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Program counter for the next cycle |
| link_we | output | 1 | Return-address write enable |
| link_data | output | 32 | Return address (`pc + 4`) |
| link_dst | output | 4 | Register index for the return address |
| halted | output | 1 | Core has executed a halt |
| illegal | output | 1 | Current opcode is undefined |
| cycle_count | output | 32 | Cycles elapsed while running |

## Verification
The assertions assume that `instr`, `src_a` and `src_b` are stable around each rising edge. They also assume that the operands belong to the instruction currently shown, because `next_pc` is checked against values sampled at the same edge. The bench changes inputs only on falling edges and keeps them for a whole cycle. It forms each instruction from a legal field layout and derives the operands from the condition it wants to exercise, for example equal values or a negative value against a positive one. Reset is applied only on a falling edge, so no property sees a partial cycle.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OP_BR_EQ  = 6'h12;
  localparam logic [OPC_W-1:0] OP_BR_NE  = 6'h13;
  localparam logic [OPC_W-1:0] OP_BR_LT  = 6'h14;
  localparam logic [OPC_W-1:0] OP_BR_GE  = 6'h15;
  localparam logic [OPC_W-1:0] OP_JUMP   = 6'h16;
  localparam logic [OPC_W-1:0] OP_JLINK  = 6'h17;
  localparam logic [OPC_W-1:0] OP_JREG   = 6'h18;
  localparam logic [OPC_W-1:0] OP_STOP   = 6'h1A;
  localparam logic [OPC_W-1:0] OP_LAST   = 6'h1B;

  typedef enum logic [2:0] {
    FLOW_SEQ,
    FLOW_BRANCH,
    FLOW_JUMP,
    FLOW_JLINK,
    FLOW_JREG,
    FLOW_STOP,
    FLOW_BAD
  } flow_e;

  typedef enum logic [1:0] {
    CMP_EQ,
    CMP_NE,
    CMP_LT,
    CMP_GE
  } cmp_e;

endpackage

// File: rtl/pcs_decode.sv
module pcs_decode
  import pcs_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output flow_e            flow,
  output cmp_e             cmp
);

  always_comb begin
    flow = FLOW_SEQ;
    cmp  = CMP_EQ;
    if (opcode > OP_LAST) begin
      flow = FLOW_BAD;
    end else begin
      case (opcode)
        OP_BR_EQ: begin flow = FLOW_BRANCH; cmp = CMP_EQ; end
        OP_BR_NE: begin flow = FLOW_BRANCH; cmp = CMP_NE; end
        OP_BR_LT: begin flow = FLOW_BRANCH; cmp = CMP_LT; end
        OP_BR_GE: begin flow = FLOW_BRANCH; cmp = CMP_GE; end
        OP_JUMP:  flow = FLOW_JUMP;
        OP_JLINK: flow = FLOW_JLINK;
        OP_JREG:  flow = FLOW_JREG;
        OP_STOP:  flow = FLOW_STOP;
        default:  flow = FLOW_SEQ;
      endcase
    end
  end

endmodule

// File: rtl/pcs_cond.sv
module pcs_cond
  import pcs_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] lhs,
  input  logic [XLEN-1:0] rhs,
  input  cmp_e            cmp,
  output logic            take
);

  function automatic logic signed_less(input logic [XLEN-1:0] a,
                                       input logic [XLEN-1:0] b);
    return $signed(a) < $signed(b);
  endfunction

  logic same;
  logic below;

  assign same  = (lhs == rhs);
  assign below = signed_less(lhs, rhs);

  always_comb begin
    case (cmp)
      CMP_EQ:  take = same;
      CMP_NE:  take = !same;
      CMP_LT:  take = below;
      CMP_GE:  take = !below;
      default: take = 1'b0;
    endcase
  end

endmodule

// File: rtl/pcs_target.sv
module pcs_target #(
  parameter int XLEN   = 32,
  parameter int BOFS_W = 18,
  parameter int JOFS_W = 22
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] instr,
  output logic [XLEN-1:0] seq_pc,
  output logic [XLEN-1:0] br_pc,
  output logic [XLEN-1:0] jmp_pc
);

  localparam int INSTR_BYTES = XLEN / 8;
  localparam int SHIFT       = $clog2(INSTR_BYTES);

  function automatic logic [XLEN-1:0] step_fwd(input logic [XLEN-1:0] base);
    return base + XLEN'(INSTR_BYTES);
  endfunction

  logic [XLEN-1:0] rel [2];

  for (genvar g = 0; g < 2; g++) begin : g_rel
    localparam int OW = (g == 0) ? BOFS_W : JOFS_W;
    logic [XLEN-1:0] ext;
    assign ext    = {{(XLEN-OW){instr[OW-1]}}, instr[OW-1:0]};
    assign rel[g] = pc + (ext << SHIFT);
  end

  assign seq_pc = step_fwd(pc);
  assign br_pc  = rel[0];
  assign jmp_pc = rel[1];

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcs_pkg::*;
#(
  parameter int               XLEN     = 32,
  parameter int               REG_AW   = 4,
  parameter int               BOFS_W   = 18,
  parameter int               JOFS_W   = 22,
  parameter int               CNT_W    = 32,
  parameter logic [XLEN-1:0]  RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   instr,
  input  logic [XLEN-1:0]   src_a,
  input  logic [XLEN-1:0]   src_b,
  output logic [XLEN-1:0]   pc,
  output logic [XLEN-1:0]   next_pc,
  output logic              link_we,
  output logic [XLEN-1:0]   link_data,
  output logic [REG_AW-1:0] link_dst,
  output logic              halted,
  output logic              illegal,
  output logic [CNT_W-1:0]  cycle_count
);

  localparam int OPC_LSB = XLEN - OPC_W;
  localparam int DST_LSB = OPC_LSB - REG_AW;

  logic [XLEN-1:0]   pc_q;
  logic              halt_q;
  logic [CNT_W-1:0]  cnt_q;

  flow_e             flow;
  cmp_e              cmp;
  logic              br_take;
  logic [XLEN-1:0]   seq_pc;
  logic [XLEN-1:0]   br_pc;
  logic [XLEN-1:0]   jmp_pc;
  logic [REG_AW-1:0] dst_field;

  // Named events for the checker and for waveform reading
  logic              ev_stop;
  logic              ev_redirect;
  logic              ev_link;

  pcs_decode u_decode (
    .opcode (instr[XLEN-1 -: OPC_W]),
    .flow   (flow),
    .cmp    (cmp)
  );

  pcs_cond #(.XLEN(XLEN)) u_cond (
    .lhs  (src_a),
    .rhs  (src_b),
    .cmp  (cmp),
    .take (br_take)
  );

  pcs_target #(.XLEN(XLEN), .BOFS_W(BOFS_W), .JOFS_W(JOFS_W)) u_target (
    .pc     (pc_q),
    .instr  (instr),
    .seq_pc (seq_pc),
    .br_pc  (br_pc),
    .jmp_pc (jmp_pc)
  );

  assign dst_field   = instr[DST_LSB +: REG_AW];
  assign ev_stop     = !halt_q && (flow == FLOW_STOP);
  assign ev_link     = !halt_q && (flow == FLOW_JLINK) && (dst_field != '0);
  assign ev_redirect = !halt_q && ((flow == FLOW_JUMP) || (flow == FLOW_JLINK) ||
                                   (flow == FLOW_JREG) ||
                                   ((flow == FLOW_BRANCH) && br_take));

  always_comb begin
    next_pc = seq_pc;
    if (halt_q) begin
      next_pc = pc_q;
    end else begin
      case (flow)
        FLOW_BRANCH: next_pc = br_take ? br_pc : seq_pc;
        FLOW_JUMP,
        FLOW_JLINK:  next_pc = jmp_pc;
        FLOW_JREG:   next_pc = src_a;
        FLOW_STOP:   next_pc = pc_q;
        default:     next_pc = seq_pc;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= RESET_PC;
      halt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!halt_q) begin
      pc_q   <= next_pc;
      cnt_q  <= cnt_q + CNT_W'(1);
      halt_q <= ev_stop;
    end
  end

  assign pc          = pc_q;
  assign halted      = halt_q;
  assign cycle_count = cnt_q;
  assign link_we     = ev_link;
  assign link_data   = seq_pc;
  assign link_dst    = dst_field;
  assign illegal     = !halt_q && (flow == FLOW_BAD);

endmodule

// File: rtl/pc_sequencer_checker.sv
module pc_sequencer_checker #(
  parameter int XLEN   = 32,
  parameter int REG_AW = 4,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [XLEN-1:0]   pc,
  input logic [XLEN-1:0]   next_pc,
  input logic              link_we,
  input logic [XLEN-1:0]   link_data,
  input logic [REG_AW-1:0] link_dst,
  input logic              halted,
  input logic              illegal,
  input logic [CNT_W-1:0]  cycle_count
);

  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R11
  a_r11_pc_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(halted)) |-> (pc == $past(next_pc)));

  // R8
  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(halted)) |-> halted);

  // R9
  a_r9_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(halted)) |-> (cycle_count == $past(cycle_count) + CNT_W'(1)));

  a_r9_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(halted)) |-> $stable(cycle_count));

  // R12
  a_r12_halted_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (next_pc == pc && !link_we && !illegal));

  // R6
  a_r6_link_target: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (link_dst != '0 && link_data == pc + XLEN'(4)));

  // R10
  a_r10_illegal_flow: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (next_pc == pc + XLEN'(4) && !link_we));

endmodule

bind pc_sequencer pc_sequencer_checker #(
  .XLEN(XLEN), .REG_AW(REG_AW), .CNT_W(CNT_W)
) u_pcs_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pc          (pc),
  .next_pc     (next_pc),
  .link_we     (link_we),
  .link_data   (link_data),
  .link_dst    (link_dst),
  .halted      (halted),
  .illegal     (illegal),
  .cycle_count (cycle_count)
);

// File: tb/pc_sequencer_bench.sv
`timescale 1ns/1ps
module pc_sequencer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = 32'h6C00_0000;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [31:0] pc, next_pc, link_data, cycle_count;
  logic        link_we, halted, illegal;
  logic [3:0]  link_dst;

  always #5 clk = ~clk;

  pc_sequencer u_pc_sequencer (
    .clk(clk), .rst_n(rst_n), .instr(instr), .src_a(src_a), .src_b(src_b),
    .pc(pc), .next_pc(next_pc), .link_we(link_we), .link_data(link_data),
    .link_dst(link_dst), .halted(halted), .illegal(illegal),
    .cycle_count(cycle_count)
  );

  typedef struct {
    logic [31:0] pc;
    logic [31:0] npc;
    logic        lwe;
    logic [31:0] ldata;
    logic [3:0]  ldst;
    logic        halt;
    logic        ill;
    logic [31:0] cnt;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;

  logic [31:0] m_pc;
  logic        m_halt;
  logic [31:0] m_cnt;

  function automatic logic [31:0] enc_b(input logic [5:0] op, input logic [17:0] off);
    return {op, 4'd1, 4'd2, off};
  endfunction

  function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [3:0] rd,
                                        input logic [21:0] off);
    return {op, rd, off};
  endfunction

  task automatic drive(input logic [31:0] ins, input logic [31:0] a,
                       input logic [31:0] b, input string tag);
    exp_t e;
    logic signed [31:0] bo, jo;
    logic [5:0] op;
    logic tk;
    instr = ins; src_a = a; src_b = b;
    op = ins[31:26];
    bo = $signed(ins[17:0]);
    jo = $signed(ins[21:0]);
    e.pc = m_pc; e.halt = m_halt; e.cnt = m_cnt; e.tag = tag;
    e.npc = m_pc + 32'd4; e.lwe = 1'b0; e.ldata = m_pc + 32'd4;
    e.ldst = ins[25:22]; e.ill = 1'b0;
    tk = 1'b0;
    if (op == 6'h12) tk = (a == b);
    if (op == 6'h13) tk = (a != b);
    if (op == 6'h14) tk = ($signed(a) < $signed(b));
    if (op == 6'h15) tk = !($signed(a) < $signed(b));
    if (tk) e.npc = m_pc + 32'(bo * 4);
    if (op == 6'h16 || op == 6'h17) e.npc = m_pc + 32'(jo * 4);
    if (op == 6'h17) e.lwe = (ins[25:22] != 4'd0);
    if (op == 6'h18) e.npc = a;
    if (op == 6'h1A) e.npc = m_pc;
    if (op >= 6'h1C) e.ill = 1'b1;
    if (m_halt) begin
      e.npc = m_pc; e.lwe = 1'b0; e.ill = 1'b0;
    end
    q.push_back(e);
    if (!m_halt) begin
      m_pc  = e.npc;
      m_cnt = m_cnt + 1;
      if (op == 6'h1A) m_halt = 1'b1;
    end
    @(negedge clk);
  endtask

  // Monitor: pops expectations mid-cycle, after the driver has settled inputs
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (pc !== e.pc || next_pc !== e.npc || link_we !== e.lwe ||
            (e.lwe && (link_data !== e.ldata || link_dst !== e.ldst)) ||
            halted !== e.halt || illegal !== e.ill || cycle_count !== e.cnt) begin
          n_bad++;
          $display("FAIL %s: got pc=%h npc=%h lwe=%b ld=%h dst=%0d h=%b ill=%b cnt=%0d exp pc=%h npc=%h lwe=%b ld=%h dst=%0d h=%b ill=%b cnt=%0d",
                   e.tag, pc, next_pc, link_we, link_data, link_dst, halted, illegal,
                   cycle_count, e.pc, e.npc, e.lwe, e.ldata, e.ldst, e.halt, e.ill, e.cnt);
        end
      end
    end
  end

  task automatic check_reset(input string tag);
    #1;
    n_chk++;
    if (pc !== 32'd0 || halted !== 1'b0 || cycle_count !== 32'd0) begin
      n_bad++;
      $display("FAIL %s: got pc=%h h=%b cnt=%0d exp pc=0 h=0 cnt=0",
               tag, pc, halted, cycle_count);
    end
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: got running exp finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_pc = 0; m_halt = 0; m_cnt = 0;
    repeat (2) @(negedge clk);
    check_reset("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    drive(32'h0000_0000, 5, 3, "R2 add sequential");
    drive(32'h6400_0000, 0, 0, "R2 upper-immediate sequential");
    drive(32'h6C00_0000, 0, 0, "R2 nop sequential");
    drive(32'h4400_0000, 0, 0, "R2 store sequential");
    drive(enc_b(6'h12, 18'd16), 7, 7, "R3 eq taken");
    drive(enc_b(6'h12, 18'd16), 7, 8, "R3 eq not taken");
    drive(enc_b(6'h13, 18'h3FFFC), 1, 2, "R3 ne taken backward");
    drive(enc_b(6'h13, 18'd5), 9, 9, "R3 ne not taken");
    drive(enc_b(6'h12, 18'h1FFFF), 0, 0, "R3 eq max forward offset");
    drive(enc_b(6'h12, 18'h20000), 0, 0, "R3 eq max backward offset");
    drive(enc_b(6'h14, 18'd8), 32'hFFFF_FFFF, 1, "R4 lt signed taken");
    drive(enc_b(6'h14, 18'd8), 1, 32'hFFFF_FFFF, "R4 lt signed not taken");
    drive(enc_b(6'h15, 18'd3), 4, 4, "R4 ge equal taken");
    drive(enc_b(6'h15, 18'd3), 32'h8000_0000, 32'h7FFF_FFFF, "R4 ge not taken");
    drive(enc_j(6'h16, 4'd0, 22'h3FFFF0), 0, 0, "R5 jump backward");
    drive(enc_j(6'h16, 4'd0, 22'h1FFFFF), 0, 0, "R5 jump max forward");
    drive(enc_j(6'h17, 4'd15, 22'd10), 0, 0, "R6 link to r15");
    drive(enc_j(6'h17, 4'd0, 22'd2), 0, 0, "R6 link to r0 suppressed");
    drive(32'h6000_0000, 32'h0000_1000, 0, "R7 register jump");
    drive(32'hFC00_0000, 0, 0, "R10 opcode 0x3F illegal");
    drive(32'h7000_0000, 0, 0, "R10 opcode 0x1C illegal");
    drive(32'h6000_0000, 32'h0000_0200, 0, "R11 register jump before halt");
    drive(32'h6800_0000, 0, 0, "R8 halt instruction");
    drive(32'h0000_0000, 0, 0, "R8 R9 halted frozen");
    drive(enc_j(6'h17, 4'd3, 22'd4), 0, 0, "R12 link ignored while halted");
    drive(32'h6000_0000, 32'h0000_4000, 0, "R12 register jump ignored");
    drive(32'hFC00_0000, 0, 0, "R12 illegal quiet while halted");
    drive(32'h6C00_0000, 0, 0, "R9 count held");
    rst_n = 1'b0;
    m_pc = 0; m_halt = 0; m_cnt = 0;
    check_reset("R1 R8 reset clears halt");
    @(negedge clk);
    rst_n = 1'b1;
    drive(32'h6C00_0000, 0, 0, "R1 first cycle after reset");
    drive(32'h6C00_0000, 0, 0, "R9 counting resumes");
    drive(enc_b(6'h15, 18'd1), 32'hFFFF_FFFE, 32'hFFFF_FFFD, "R4 ge negatives taken");
    @(negedge clk);
    #6;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule